// File: doc/BRIEF.md
# Coded Entry Lock with Failure Lockout

This block is a small keypad-free door lock. A code is set on a bank of binary switches and confirmed by pressing a single enter button. The raw button is brought into the clock domain, filtered so that contact bounce cannot act as a press, and turned into one confirm event per real press. On that event the switch value is captured and tested for equality against a code fixed at build time. A match lights the green lamp for a fixed time. A mismatch lights the red lamp for the same time.

Wrong entries are counted. A correct entry clears that count. When the count of wrong entries reaches the configured limit (three by default), the lock falls into a latched lockout. In lockout the red lamp flashes from a free-running divider, further presses are ignored, and only reset releases the lock. All timing constants (filter window, lamp hold time, flash half-period) are parameters so a simulation can use small values.

Top module: `pass_lock`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `grant_led`, `deny_led` and `lockout` are all 0.
- R2: The synchronised button must hold a new level for `DEBOUNCE_CYC` consecutive cycles before it is accepted. A high pulse shorter than that produces no attempt and lights no lamp.
- R3: The switch value is captured on the clock edge at which the confirm event is consumed. A change of the switches after that edge does not alter the outcome of the attempt.
- R4: An attempt matches only when every bit of the captured code equals the matching bit of `SECRET`. The default `SECRET` is 4'b1011, with bit 3 being the leftmost switch. Any single differing bit is a mismatch.
- R5: A match drives `grant_led` high for exactly `HOLD_CYC` cycles. It rises after the edge that is `DEBOUNCE_CYC`+3 edges after the first edge that samples the button high.
- R6: A mismatch that does not reach the limit drives `deny_led` high for exactly `HOLD_CYC` cycles, with the same latency as R5. The two lamps are never lit together.
- R7: The mismatch that brings the wrong-entry count to `MAX_FAILS` sets `lockout` instead of a timed red lamp. `lockout` then stays high until reset.
- R8: While `lockout` is high, `deny_led` follows a free-running divider that toggles every `BLINK_HALF` cycles.
- R9: A matching attempt resets the wrong-entry count to zero. After it, `MAX_FAILS`-1 further mismatches do not lock.
- R10: Presses made while a lamp is being held, or while locked out, are ignored. In lockout, a correct code lights no green lamp.
- R11: Holding the button for any length produces a single attempt, because only the accepted rising level counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_sw | input | CODE_W | Code switches, one bit per switch |
| enter_btn | input | 1 | Raw, unsynchronised enter button |
| grant_led | output | 1 | Green lamp, access granted |
| deny_led | output | 1 | Red lamp, denied or flashing in lockout |
| lockout | output | 1 | High while the lock is latched out |

## Verification
Counted from the first edge that samples the button high, the synchroniser takes two edges. The filter then needs `DEBOUNCE_CYC` edges to emit its registered confirm pulse, one more edge captures the code, and one more sets the lamp. The lamp is therefore visible after edge `DEBOUNCE_CYC`+3 and lasts `HOLD_CYC` cycles, while the flash divider runs from reset regardless of state. A behavioural model in the bench advances on the same edges, and all three outputs are compared with it at every falling edge. Each attempt is also judged over a window wide enough to contain the whole latency plus hold, by counting lit cycles instead of sampling a single instant.

// File: rtl/lock_pkg.sv
package lock_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_GRANT = 3'd2,
        ST_DENY  = 3'd3,
        ST_LOCK  = 3'd4
    } lock_state_e;

endpackage

// File: rtl/lock_debounce.sv
module lock_debounce #(
    parameter int STABLE_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic press
);
    localparam int CW = (STABLE_CYC < 2) ? 1 : $clog2(STABLE_CYC);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          lvl;
        logic [CW-1:0] cnt;
        logic          pulse;
    } deb_t;

    deb_t deb_d, deb_q;

    always_comb begin
        deb_d       = deb_q;
        deb_d.s1    = raw_in;
        deb_d.s2    = deb_q.s1;
        deb_d.pulse = 1'b0;
        deb_d.cnt   = '0;
        if (deb_q.s2 != deb_q.lvl) begin
            if (deb_q.cnt == LAST) begin
                deb_d.lvl   = deb_q.s2;
                deb_d.pulse = deb_q.s2;
            end else begin
                deb_d.cnt = deb_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) deb_q <= '0;
        else     deb_q <= deb_d;
    end

    assign press = deb_q.pulse;
endmodule

// File: rtl/lock_match.sv
module lock_match #(
    parameter int                CODE_W = 4,
    parameter logic [CODE_W-1:0] SECRET = 4'b1011
) (
    input  logic [CODE_W-1:0] code,
    output logic              hit
);
    logic [CODE_W-1:0] bit_eq;
    logic [CODE_W:0]   chain;

    assign chain[0] = 1'b1;

    genvar i;
    generate
        for (i = 0; i < CODE_W; i++) begin : g_bit
            assign bit_eq[i]  = ~(code[i] ^ SECRET[i]);
            assign chain[i+1] = chain[i] & bit_eq[i];
        end
    endgenerate

    assign hit = chain[CODE_W];
endmodule

// File: rtl/lock_blinker.sv
module lock_blinker #(
    parameter int HALF = 8
) (
    input  logic clk,
    input  logic rst,
    output logic phase
);
    localparam int BW = (HALF < 2) ? 1 : $clog2(HALF);
    localparam logic [BW-1:0] WRAP = BW'(HALF - 1);

    typedef struct packed {
        logic [BW-1:0] div;
        logic          ph;
    } blk_t;

    blk_t blk_d, blk_q;

    always_comb begin
        blk_d = blk_q;
        if (blk_q.div == WRAP) begin
            blk_d.div = '0;
            blk_d.ph  = ~blk_q.ph;
        end else begin
            blk_d.div = blk_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) blk_q <= '0;
        else     blk_q <= blk_d;
    end

    assign phase = blk_q.ph;
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
    import lock_pkg::*;
#(
    parameter int CODE_W    = 4,
    parameter int HOLD_CYC  = 8,
    parameter int MAX_FAILS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              press,
    input  logic [CODE_W-1:0] code_sw,
    input  logic              hit,
    input  logic              blink,
    output logic [CODE_W-1:0] held_code,
    output lock_state_e       state,
    output logic              grant_led,
    output logic              deny_led,
    output logic              lockout
);
    localparam int HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
    localparam int FW = $clog2(MAX_FAILS + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);
    localparam logic [FW-1:0] FAIL_LAST = FW'(MAX_FAILS - 1);

    typedef struct packed {
        lock_state_e       st;
        logic [CODE_W-1:0] code;
        logic [FW-1:0]     fails;
        logic [HW-1:0]     hold;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (press) begin
                    ctl_d.code = code_sw;
                    ctl_d.st   = ST_CHECK;
                end
            end
            ST_CHECK: begin
                ctl_d.hold = '0;
                if (hit) begin
                    ctl_d.fails = '0;
                    ctl_d.st    = ST_GRANT;
                end else if (ctl_q.fails == FAIL_LAST) begin
                    ctl_d.fails = ctl_q.fails + 1'b1;
                    ctl_d.st    = ST_LOCK;
                end else begin
                    ctl_d.fails = ctl_q.fails + 1'b1;
                    ctl_d.st    = ST_DENY;
                end
            end
            ST_GRANT, ST_DENY: begin
                if (ctl_q.hold == HOLD_LAST) begin
                    ctl_d.hold = '0;
                    ctl_d.st   = ST_IDLE;
                end else begin
                    ctl_d.hold = ctl_q.hold + 1'b1;
                end
            end
            ST_LOCK: ctl_d.st = ST_LOCK;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.code  <= '0;
            ctl_q.fails <= '0;
            ctl_q.hold  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign held_code = ctl_q.code;
    assign state     = ctl_q.st;
    assign grant_led = (ctl_q.st == ST_GRANT);
    assign lockout   = (ctl_q.st == ST_LOCK);
    assign deny_led  = (ctl_q.st == ST_DENY) | ((ctl_q.st == ST_LOCK) & blink);
endmodule

// File: rtl/pass_lock.sv
module pass_lock
    import lock_pkg::*;
#(
    parameter int                CODE_W       = 4,
    parameter logic [CODE_W-1:0] SECRET       = 4'b1011,
    parameter int                DEBOUNCE_CYC = 100000,
    parameter int                HOLD_CYC     = 25000000,
    parameter int                BLINK_HALF   = 6250000,
    parameter int                MAX_FAILS    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_sw,
    input  logic              enter_btn,
    output logic              grant_led,
    output logic              deny_led,
    output logic              lockout
);
    logic              press;
    logic              hit;
    logic              blink;
    logic [CODE_W-1:0] held_code;
    lock_state_e       state;

    lock_debounce #(.STABLE_CYC(DEBOUNCE_CYC)) u_deb (
        .clk    (clk),
        .rst    (rst),
        .raw_in (enter_btn),
        .press  (press)
    );

    lock_match #(.CODE_W(CODE_W), .SECRET(SECRET)) u_match (
        .code (held_code),
        .hit  (hit)
    );

    lock_blinker #(.HALF(BLINK_HALF)) u_blink (
        .clk   (clk),
        .rst   (rst),
        .phase (blink)
    );

    lock_ctrl #(
        .CODE_W    (CODE_W),
        .HOLD_CYC  (HOLD_CYC),
        .MAX_FAILS (MAX_FAILS)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .press     (press),
        .code_sw   (code_sw),
        .hit       (hit),
        .blink     (blink),
        .held_code (held_code),
        .state     (state),
        .grant_led (grant_led),
        .deny_led  (deny_led),
        .lockout   (lockout)
    );
endmodule

// File: rtl/pass_lock_checker.sv
module pass_lock_checker
    import lock_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        press,
    input lock_state_e state,
    input logic        grant_led,
    input logic        deny_led,
    input logic        lockout
);
    AST_LAMPS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(grant_led && deny_led)); // R6

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        lockout |=> lockout); // R7

    AST_LOCK_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        lockout |-> !grant_led); // R10

    AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        press |=> !press); // R11

    AST_CHECK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK) |=> (state != ST_CHECK)); // R4

    AST_GRANT_NOT_FROM_LOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_led) |-> !$past(lockout)); // R7
endmodule

bind pass_lock pass_lock_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .press     (press),
    .state     (state),
    .grant_led (grant_led),
    .deny_led  (deny_led),
    .lockout   (lockout)
);

// File: tb/tb_pass_lock.sv
module tb_pass_lock;
    localparam int       W     = 4;
    localparam logic [3:0] KEY = 4'b1011;
    localparam int       DEB   = 4;
    localparam int       HOLD  = 12;
    localparam int       BLK   = 5;
    localparam int       MAXF  = 3;
    localparam int       WIN   = 50;

    localparam int M_IDLE = 0, M_CHECK = 1, M_GRANT = 2, M_DENY = 3, M_LOCK = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] code_sw = '0;
    logic         enter_btn = 1'b0;
    logic         grant_led, deny_led, lockout;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pass_lock #(
        .CODE_W(W), .SECRET(KEY), .DEBOUNCE_CYC(DEB),
        .HOLD_CYC(HOLD), .BLINK_HALF(BLK), .MAX_FAILS(MAXF)
    ) dut (
        .clk(clk), .rst(rst), .code_sw(code_sw), .enter_btn(enter_btn),
        .grant_led(grant_led), .deny_led(deny_led), .lockout(lockout)
    );

    // behavioural reference
    bit sq[$];
    int lvl, dcnt, pulse, st, cap, fails, hold, bdiv, blink;

    always @(posedge clk) begin
        if (rst) begin
            sq = '{0, 0};
            lvl = 0; dcnt = 0; pulse = 0; st = M_IDLE; cap = 0;
            fails = 0; hold = 0; bdiv = 0; blink = 0;
        end else begin
            int seen, npulse;
            seen = sq[0];
            void'(sq.pop_front());
            sq.push_back(enter_btn);
            npulse = 0;
            if (seen != lvl) begin
                if (dcnt >= DEB - 1) begin lvl = seen; npulse = seen; dcnt = 0; end
                else dcnt++;
            end else dcnt = 0;
            case (st)
                M_IDLE:  if (pulse != 0) begin cap = code_sw; st = M_CHECK; end
                M_CHECK: begin
                    hold = 0;
                    if (cap == KEY) begin fails = 0; st = M_GRANT; end
                    else begin fails++; st = (fails >= MAXF) ? M_LOCK : M_DENY; end
                end
                M_GRANT, M_DENY: begin
                    if (hold == HOLD - 1) begin hold = 0; st = M_IDLE; end
                    else hold++;
                end
                default: st = M_LOCK;
            endcase
            pulse = npulse;
            if (bdiv == BLK - 1) begin bdiv = 0; blink = 1 - blink; end
            else bdiv++;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference (R5 R6 R7 R8)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R5 grant_led", grant_led, st == M_GRANT);
            chk("R8 deny_led", deny_led, (st == M_DENY) || (st == M_LOCK && blink != 0));
            chk("R7 lockout", lockout, st == M_LOCK);
        end
    end

    int g_cnt, r_cnt;
    bit counting = 1'b0;
    always @(negedge clk) begin
        if (counting) begin
            g_cnt += grant_led;
            r_cnt += deny_led;
        end
    end

    task automatic attempt(logic [W-1:0] c, int len, int swap_after);
        g_cnt = 0; r_cnt = 0; counting = 1'b1;
        @(negedge clk);
        code_sw = c;
        enter_btn = 1'b1;
        for (int i = 0; i < WIN; i++) begin
            if (i == len) enter_btn = 1'b0;
            if (swap_after > 0 && i == swap_after) code_sw = ~c;
            @(negedge clk);
        end
        counting = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int last, since, seen_iv;
        repeat (3) @(negedge clk);
        chk("R1 grant in reset", grant_led, 0);
        chk("R1 deny in reset", deny_led, 0);
        chk("R1 lockout in reset", lockout, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 lamps after reset", grant_led | deny_led | lockout, 0);

        attempt(4'b1011, 8, 0);
        chk("R4 R5 match green cycles", g_cnt, HOLD);
        chk("R5 match no red", r_cnt, 0);

        attempt(4'b0011, 8, 0);
        chk("R6 msb differs red cycles", r_cnt, HOLD);
        chk("R4 msb differs no green", g_cnt, 0);

        attempt(4'b1010, 8, 0);
        chk("R4 lsb differs red", r_cnt, HOLD);

        attempt(4'b1011, 8, 0);
        chk("R9 match after two fails", g_cnt, HOLD);

        attempt(4'b0000, 8, 0);
        attempt(4'b1111, 8, 0);
        chk("R9 two fails after clear red", r_cnt, HOLD);
        chk("R9 not locked after clear", lockout, 0);

        attempt(4'b1011, 8, 0);
        chk("R9 match clears again", g_cnt, HOLD);

        attempt(4'b1011, 2, 0);
        chk("R2 short pulse no green", g_cnt, 0);
        chk("R2 short pulse no red", r_cnt, 0);

        attempt(4'b0110, 45, 0);
        chk("R11 long hold one attempt red", r_cnt, HOLD);

        attempt(4'b1011, 10, 10);
        chk("R3 later switch change ignored", g_cnt, HOLD);

        attempt(4'b0001, 8, 0);
        attempt(4'b0010, 8, 0);
        chk("R6 second fail red", r_cnt, HOLD);
        chk("R6 not yet locked", lockout, 0);
        attempt(4'b0100, 8, 0);
        chk("R7 third fail locks", lockout, 1);
        chk("R7 third fail no green", g_cnt, 0);

        last = deny_led; since = 0; seen_iv = 0;
        while (seen_iv < 5) begin
            @(negedge clk);
            since++;
            if (deny_led != last) begin
                if (seen_iv > 0) chk("R8 flash half period", since, BLK);
                seen_iv++;
                since = 0;
                last = deny_led;
            end
        end

        attempt(4'b1011, 8, 0);
        chk("R10 correct code in lockout no green", g_cnt, 0);
        chk("R10 still locked", lockout, 1);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset releases lockout", lockout, 0);
        chk("R1 reset clears red", deny_led, 0);

        attempt(4'b1011, 8, 0);
        chk("R5 grant after release", g_cnt, HOLD);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule